// File: doc/BRIEF.md
# Two-Level Overcurrent Supervisor with Hiccup Retry

This block is the digital supervisor for one port of a USB power switch. Comparators outside the block report whether the load is above the primary limit, above the secondary limit or above the fast-trip level. Two more inputs report junction temperature: a hot flag and a cooled flag. A last input reports port undervoltage. From these flags the supervisor drives a switch enable, a one-cycle soft-start request to the ramp generator, and a threshold select that tells the regulation loop which limit applies. The secondary limit is 1.6 times the primary limit. The supervisor also drives three status flags: fault, hiccup and thermal-off.

All durations are counted in pulses of a `tick` timebase, and each one is set by a parameter, so a bench can scale them down. Each port has its own instance, so a fault on one port never reaches another port.

The main machine has seven states. OFF is undervoltage. ON is normal conduction. LIMIT means the port is current limiting and the overcurrent timeout is running. HIC_OFF and HIC_ON are the hiccup off-window and on-window. FAST_OFF is the recovery after a fast trip. THERM_OFF is thermal shutdown.

Its transitions are:
- any state to OFF on undervoltage;
- OFF to ON;
- ON to LIMIT when limiting starts, and LIMIT back to ON when it stops;
- LIMIT to HIC_OFF when the timeout expires;
- HIC_OFF to HIC_ON when the off-window ends;
- HIC_ON to HIC_OFF or to ON when the on-window ends;
- any conducting state to FAST_OFF on a fast trip, and FAST_OFF to ON when its window ends;
- any conducting state to THERM_OFF on overheat, and THERM_OFF to ON once cooled.

A second machine manages the threshold. ARMED selects the secondary limit and waits for the switch to conduct. ACTIVE keeps the secondary limit for its timed window. HOLD selects the primary limit during the re-arm holdoff.

Top module: `ocp_supervisor`

## Requirements
- R1: While `port_uv` is high, the next clock leaves `sw_en`=0 and `fault`=0, with `sel_hi`=1. The secondary limit is then armed and all timers are cleared.
- R2: `ss_req` is high for exactly one cycle, the first cycle in which `sw_en` is 1 after being 0. This includes the power-up path: the clock after `port_uv` falls sets `sw_en`=1 and `ss_req`=1.
- R3: `sel_hi`=1 selects the secondary limit. Once the switch conducts, the secondary limit stays selected for SEC_T ticks and then drops to the primary limit (`sel_hi`=0).
- R4: If `ovr_sec` is high while the secondary limit is selected and the switch conducts, `sel_hi` goes to 0 on the next clock.
- R5: After the secondary limit drops, `sel_hi` stays 0 for HOLD_T ticks. It is then selected again if the switch conducts; otherwise it is armed for the next conduction.
- R6: Current limiting means `ovr_pri` is high while `sel_hi`=0. If limiting lasts OC_T ticks without a break, the switch turns off and hiccup starts (`in_hiccup`=1).
- R7: In hiccup the switch is off for HOFF_T ticks and then on for HON_T ticks. If limiting was seen at any point in the on-window, the next off-window follows; otherwise normal operation resumes.
- R8: While conducting, `ovr_fast` turns the switch off on the next clock. After FAST_T ticks the switch restarts with a soft-start request.
- R9: `therm_hot` sets a thermal latch and `therm_cool` clears it; hot wins if both are high. While conducting, a set latch moves the block to the thermal-off state two clocks after `therm_hot`. The switch restarts only after the latch is cleared. Priority among the events is undervoltage, then thermal, then fast trip.
- R10: `fault` is 1 in the hiccup off, hiccup on, fast-trip recovery and thermal-off states. `in_hiccup` marks the two hiccup states and `therm_off` marks the thermal-off state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase pulse; all durations count these |
| port_uv | input | 1 | Port undervoltage |
| ovr_pri | input | 1 | Load above primary limit |
| ovr_sec | input | 1 | Load above secondary limit |
| ovr_fast | input | 1 | Load above fast-trip level |
| therm_hot | input | 1 | Junction above thermal trip point |
| therm_cool | input | 1 | Junction cooled below the release point |
| sw_en | output | 1 | Power switch enable |
| sel_hi | output | 1 | 1 selects the secondary limit, 0 the primary |
| ss_req | output | 1 | One-cycle soft-start request |
| fault | output | 1 | Fault status |
| in_hiccup | output | 1 | Hiccup status |
| therm_off | output | 1 | Thermal-off status |

## Verification
The hardest case is reaching hiccup while the threshold machine keeps re-arming. Each time the secondary limit comes back, it briefly masks limiting and restarts the overcurrent timeout.

The stimulus covers this in two ways. It holds a medium overload (primary flag only), so that the timeout runs only after the secondary window closes. It also holds a heavy overload (both flags), so that every re-arm drops at once.

A behavioural reference model, compared on every clock, follows the ticks that land at each state entry. Undervoltage is also applied in the middle of hiccup, and a thermal event is applied together with a fast trip, to exercise the priority order.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    typedef enum logic [2:0] {
        M_OFF,
        M_ON,
        M_LIMIT,
        M_HIC_OFF,
        M_HIC_ON,
        M_FAST_OFF,
        M_THERM_OFF
    } mode_t;

    typedef enum logic [1:0] {
        H_ARMED,
        H_ACTIVE,
        H_HOLD
    } hi_t;

endpackage

// File: rtl/ocp_tick_timer.sv
module ocp_tick_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (tick) cnt <= cnt + 1'b1;
    end

    // Fires on the tick that completes 'limit' ticks in the current state.
    assign done = tick && (cnt == (limit - {{(W-1){1'b0}}, 1'b1}));

endmodule

// File: rtl/ocp_thermal_gate.sv
module ocp_thermal_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic hot,
    input  logic cool,
    output logic blk
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    blk <= 1'b0;
        else if (hot)  blk <= 1'b1;
        else if (cool) blk <= 1'b0;
    end

    AST_HOT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        hot |=> blk); // R9
    AST_HOLD_UNTIL_COOL: assert property (@(posedge clk) disable iff (!rst_n)
        (blk && !cool) |=> blk); // R9

endmodule

// File: rtl/ocp_sec_arm.sv
module ocp_sec_arm
    import ocp_pkg::*;
#(
    parameter int W      = 8,
    parameter int SEC_T  = 20,
    parameter int HOLD_T = 160
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic uv,
    input  logic sw_on,
    input  logic ovr_sec,
    output logic sel_hi
);
    hi_t          hs_q, hs_d;
    logic [W-1:0] lim_val;
    logic         t_done;

    always_comb begin
        unique case (hs_q)
            H_ACTIVE: lim_val = W'(SEC_T);
            H_HOLD:   lim_val = W'(HOLD_T);
            default:  lim_val = W'(1);
        endcase
    end

    ocp_tick_timer #(.W(W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (hs_d != hs_q),
        .tick  (tick),
        .limit (lim_val),
        .done  (t_done)
    );

    always_comb begin
        hs_d = hs_q;
        if (uv) begin
            hs_d = H_ARMED;
        end else begin
            unique case (hs_q)
                H_ARMED:  if (sw_on) hs_d = ovr_sec ? H_HOLD : H_ACTIVE;
                H_ACTIVE: if (ovr_sec || t_done) hs_d = H_HOLD;
                H_HOLD:   if (t_done) hs_d = sw_on ? H_ACTIVE : H_ARMED;
                default:  hs_d = H_ARMED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hs_q <= H_ARMED;
        else        hs_q <= hs_d;
    end

    assign sel_hi = (hs_q != H_HOLD);

    AST_SEC_EARLY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_hi && ovr_sec && sw_on && !uv) |=> !sel_hi); // R4
    AST_UV_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        uv |=> sel_hi); // R1

endmodule

// File: rtl/ocp_supervisor.sv
module ocp_supervisor
    import ocp_pkg::*;
#(
    parameter int SEC_T  = 20,
    parameter int HOLD_T = 160,
    parameter int OC_T   = 41,
    parameter int HOFF_T = 5240,
    parameter int HON_T  = 41,
    parameter int FAST_T = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic port_uv,
    input  logic ovr_pri,
    input  logic ovr_sec,
    input  logic ovr_fast,
    input  logic therm_hot,
    input  logic therm_cool,
    output logic sw_en,
    output logic sel_hi,
    output logic ss_req,
    output logic fault,
    output logic in_hiccup,
    output logic therm_off
);
    localparam int M1   = (SEC_T > HOLD_T) ? SEC_T : HOLD_T;
    localparam int M2   = (OC_T > HON_T) ? OC_T : HON_T;
    localparam int M3   = (HOFF_T > FAST_T) ? HOFF_T : FAST_T;
    localparam int M12  = (M1 > M2) ? M1 : M2;
    localparam int TMAX = (M12 > M3) ? M12 : M3;
    localparam int CW   = $clog2(TMAX + 1);

    mode_t         st_q, st_d;
    logic          blk;
    logic          sel_hi_w;
    logic          limiting;
    logic          m_done;
    logic          seen_q;
    logic          on_q;
    logic [CW-1:0] m_lim;

    ocp_thermal_gate u_therm (
        .clk   (clk),
        .rst_n (rst_n),
        .hot   (therm_hot),
        .cool  (therm_cool),
        .blk   (blk)
    );

    ocp_sec_arm #(
        .W      (CW),
        .SEC_T  (SEC_T),
        .HOLD_T (HOLD_T)
    ) u_sec (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .uv      (port_uv),
        .sw_on   (sw_en),
        .ovr_sec (ovr_sec),
        .sel_hi  (sel_hi_w)
    );

    // Limiting only counts against the primary threshold.
    assign limiting = ovr_pri && !sel_hi_w;

    always_comb begin
        unique case (st_q)
            M_LIMIT:    m_lim = CW'(OC_T);
            M_HIC_OFF:  m_lim = CW'(HOFF_T);
            M_HIC_ON:   m_lim = CW'(HON_T);
            M_FAST_OFF: m_lim = CW'(FAST_T);
            default:    m_lim = CW'(1);
        endcase
    end

    ocp_tick_timer #(.W(CW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (st_d != st_q),
        .tick  (tick),
        .limit (m_lim),
        .done  (m_done)
    );

    // Next-state process
    always_comb begin
        st_d = st_q;
        if (port_uv) begin
            st_d = M_OFF;
        end else if (sw_en && blk) begin
            st_d = M_THERM_OFF;
        end else if (sw_en && ovr_fast) begin
            st_d = M_FAST_OFF;
        end else begin
            unique case (st_q)
                M_OFF:       st_d = M_ON;
                M_ON:        if (limiting) st_d = M_LIMIT;
                M_LIMIT: begin
                    if (!limiting)   st_d = M_ON;
                    else if (m_done) st_d = M_HIC_OFF;
                end
                M_HIC_OFF:   if (m_done) st_d = M_HIC_ON;
                M_HIC_ON:    if (m_done) st_d = (seen_q || limiting) ? M_HIC_OFF : M_ON;
                M_FAST_OFF:  if (m_done) st_d = M_ON;
                M_THERM_OFF: if (!blk) st_d = M_ON;
                default:     st_d = M_OFF;
            endcase
        end
    end

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= M_OFF;
            seen_q <= 1'b0;
            on_q   <= 1'b0;
        end else begin
            st_q   <= st_d;
            seen_q <= (st_q == M_HIC_ON) && (seen_q || limiting);
            on_q   <= sw_en;
        end
    end

    // Output process
    always_comb begin
        sw_en     = (st_q == M_ON) || (st_q == M_LIMIT) || (st_q == M_HIC_ON);
        in_hiccup = (st_q == M_HIC_OFF) || (st_q == M_HIC_ON);
        therm_off = (st_q == M_THERM_OFF);
        fault     = in_hiccup || therm_off || (st_q == M_FAST_OFF);
        ss_req    = sw_en && !on_q;
        sel_hi    = sel_hi_w;
    end

    AST_UV_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        port_uv |=> (!sw_en && !fault)); // R1
    AST_SS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ss_req |=> !ss_req); // R2
    AST_FAST_TRIP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && ovr_fast && !port_uv) |=> !sw_en); // R8
    AST_HICCUP_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        in_hiccup |-> (fault && !therm_off)); // R10

endmodule

// File: tb/sim_ocp_supervisor.sv
`timescale 1ns/100ps
module sim_ocp_supervisor;
    localparam int SEC_T = 3, HOLD_T = 6, OC_T = 4, HOFF_T = 8, HON_T = 4, FAST_T = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic port_uv = 1'b1, ovr_pri = 1'b0, ovr_sec = 1'b0, ovr_fast = 1'b0;
    logic therm_hot = 1'b0, therm_cool = 1'b0;
    logic sw_en, sel_hi, ss_req, fault, in_hiccup, therm_off;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    ocp_supervisor #(
        .SEC_T(SEC_T), .HOLD_T(HOLD_T), .OC_T(OC_T),
        .HOFF_T(HOFF_T), .HON_T(HON_T), .FAST_T(FAST_T)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .port_uv(port_uv),
        .ovr_pri(ovr_pri), .ovr_sec(ovr_sec), .ovr_fast(ovr_fast),
        .therm_hot(therm_hot), .therm_cool(therm_cool),
        .sw_en(sw_en), .sel_hi(sel_hi), .ss_req(ss_req), .fault(fault),
        .in_hiccup(in_hiccup), .therm_off(therm_off)
    );

    // Timebase: one tick every second clock
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1 tick = (cyc % 2 == 0);
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    // Behavioural reference model
    // mode: 0 off 1 on 2 limit 3 hic_off 4 hic_on 5 fast_off 6 therm_off
    // hi:   0 armed 1 active 2 hold
    int mode = 0, mcnt = 0, hi = 0, hcnt = 0;
    bit hot = 0, seen = 0, was_on = 0;

    function automatic bit conducting(int m);
        return (m == 1) || (m == 2) || (m == 4);
    endfunction

    always @(posedge clk) begin
        int nm, nh, want;
        bit on, lim, mdone, hdone;
        if (!rst_n) begin
            mode = 0; mcnt = 0; hi = 0; hcnt = 0; hot = 0; seen = 0; was_on = 0;
        end else begin
            on  = conducting(mode);
            lim = ovr_pri && (hi == 2);
            want = (mode == 2) ? OC_T : (mode == 3) ? HOFF_T : (mode == 4) ? HON_T :
                   (mode == 5) ? FAST_T : 1;
            mdone = tick && (mcnt == want - 1);
            nm = mode;
            if (port_uv) nm = 0;
            else if (on && hot) nm = 6;
            else if (on && ovr_fast) nm = 5;
            else if (mode == 0) nm = 1;
            else if (mode == 1) begin if (lim) nm = 2; end
            else if (mode == 2) begin if (!lim) nm = 1; else if (mdone) nm = 3; end
            else if (mode == 3) begin if (mdone) nm = 4; end
            else if (mode == 4) begin if (mdone) nm = (seen || lim) ? 3 : 1; end
            else if (mode == 5) begin if (mdone) nm = 1; end
            else if (mode == 6) begin if (!hot) nm = 1; end
            hdone = tick && (hcnt == ((hi == 1) ? SEC_T : (hi == 2) ? HOLD_T : 1) - 1);
            nh = hi;
            if (port_uv) nh = 0;
            else if (hi == 0) begin if (on) nh = ovr_sec ? 2 : 1; end
            else if (hi == 1) begin if (ovr_sec || hdone) nh = 2; end
            else if (hdone) nh = on ? 1 : 0;
            seen = (mode == 4) && (seen || lim);
            mcnt = (nm != mode) ? 0 : (tick ? mcnt + 1 : mcnt);
            hcnt = (nh != hi) ? 0 : (tick ? hcnt + 1 : hcnt);
            if (therm_hot) hot = 1; else if (therm_cool) hot = 0;
            was_on = on;
            mode = nm;
            hi = nh;
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            chk("R7",  "sw_en",     sw_en,     conducting(mode));
            chk("R3",  "sel_hi",    sel_hi,    hi != 2);
            chk("R2",  "ss_req",    ss_req,    conducting(mode) && !was_on);
            chk("R10", "fault",     fault,     mode >= 3);
            chk("R6",  "in_hiccup", in_hiccup, (mode == 3) || (mode == 4));
            chk("R9",  "therm_off", therm_off, mode == 6);
        end
    end

    task automatic finish_run();
        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        finish_run();
    end

    task automatic wait_hiccup(input string tag);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (in_hiccup) break;
        end
        chk(tag, "hiccup reached", in_hiccup, 1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset sw_en", sw_en, 0);
        chk("R1", "reset sel_hi", sel_hi, 1);
        chk("R10", "reset fault", fault, 0);

        // Power-up
        #1 port_uv = 1'b0;
        @(negedge clk);
        chk("R2", "power-up sw_en", sw_en, 1);
        chk("R2", "power-up ss_req", ss_req, 1);
        @(negedge clk);
        chk("R2", "ss_req single", ss_req, 0);
        chk("R3", "secondary selected", sel_hi, 1);

        // Early drop on secondary exceed
        #1 ovr_sec = 1'b1;
        @(negedge clk);
        chk("R4", "early drop", sel_hi, 0);
        #1 ovr_sec = 1'b0;
        repeat (7) @(negedge clk);
        chk("R5", "holdoff keeps primary", sel_hi, 0);
        repeat (7) @(negedge clk);
        chk("R5", "re-armed after holdoff", sel_hi, 1);

        // Medium overload: primary flag only
        #1 ovr_pri = 1'b1;
        wait_hiccup("R6");
        chk("R6", "hiccup switch off", sw_en, 0);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (sw_en) break;
        end
        chk("R7", "hiccup on-window", sw_en && in_hiccup, 1);
        chk("R10", "fault in hiccup", fault, 1);
        #1 ovr_pri = 1'b0;
        repeat (60) @(negedge clk);
        chk("R7", "hiccup exit", in_hiccup, 0);
        chk("R7", "normal after hiccup", sw_en, 1);

        // Heavy overload: both flags
        #1 begin ovr_pri = 1'b1; ovr_sec = 1'b1; end
        wait_hiccup("R6");
        repeat (30) @(negedge clk);
        #1 begin ovr_pri = 1'b0; ovr_sec = 1'b0; end
        repeat (60) @(negedge clk);
        chk("R7", "recovered from heavy", sw_en, 1);

        // Fast trip
        #1 ovr_fast = 1'b1;
        @(negedge clk);
        chk("R8", "fast trip off", sw_en, 0);
        chk("R10", "fast trip fault", fault, 1);
        #1 ovr_fast = 1'b0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (sw_en) break;
        end
        chk("R8", "restart with soft start", ss_req, 1);

        // Thermal cycle
        repeat (3) @(negedge clk);
        #1 therm_hot = 1'b1;
        @(negedge clk);
        #1 therm_hot = 1'b0;
        @(negedge clk);
        chk("R9", "thermal off", therm_off, 1);
        chk("R9", "thermal switch off", sw_en, 0);
        repeat (20) @(negedge clk);
        chk("R9", "stays off until cooled", therm_off, 1);
        #1 therm_cool = 1'b1;
        @(negedge clk);
        #1 therm_cool = 1'b0;
        @(negedge clk);
        chk("R9", "restart after cool", sw_en, 1);

        // Thermal and fast trip together
        repeat (5) @(negedge clk);
        #1 begin therm_hot = 1'b1; ovr_fast = 1'b1; end
        @(negedge clk);
        #1 begin therm_hot = 1'b0; ovr_fast = 1'b0; end
        repeat (20) @(negedge clk);
        chk("R9", "thermal wins after fast trip", therm_off, 1);
        #1 therm_cool = 1'b1;
        @(negedge clk);
        #1 therm_cool = 1'b0;
        repeat (10) @(negedge clk);

        // Undervoltage during hiccup
        #1 begin ovr_pri = 1'b1; ovr_sec = 1'b1; end
        wait_hiccup("R6");
        #1 port_uv = 1'b1;
        @(negedge clk);
        chk("R1", "uv switch off", sw_en, 0);
        chk("R1", "uv clears fault", fault, 0);
        chk("R1", "uv arms secondary", sel_hi, 1);
        #1 begin ovr_pri = 1'b0; ovr_sec = 1'b0; end
        repeat (10) @(negedge clk);
        #1 port_uv = 1'b0;
        repeat (30) @(negedge clk);
        finish_run();
    end

endmodule